// File: doc/BRIEF.md
# Embedded Sync Code Inserter

This block formats a video sample stream for a link that carries its timing inside the data. A pixel counter restarts at every leading edge of horizontal sync. The pixel present in that cycle is pixel 0. Programmable absolute start and stop pixel numbers define the active-video window. The four sample slots just before the window carry a start-of-active-video timing code. The four slots just after it carry an end-of-active-video code. All other non-active slots carry blanking levels. Each code is the word sequence all-ones, zero, zero, status word. The status word carries the field bit, the vertical-blanking bit and the start/end bit, together with protection bits.

A line counter restarts at the leading edge of vertical sync and advances at every horizontal sync leading edge. The vertical-blanking bit comes from two programmable line bounds. The field bit comes from two signed line offsets and is forced low in progressive operation. The field bit is also presented on a field ID output. The output either passes three full-rate component buses, or packs 4:2:2 data with luma on one bus and alternating Cb/Cr samples on the second bus. The stop position is loaded through a byte-wide write port. Writing the low byte only stages it. The new position takes effect when the upper byte is written. All outputs are registered and follow their input sample by one clock.

Top module: `embsync_inserter`

## Requirements
- R1: `av_out` is 1 exactly for the samples whose pixel number p satisfies start <= p < stop. Pixel 0 is the sample presented in the cycle where `hs_in` rises. Each output appears one clock after its input sample.
- R2: The samples at pixel numbers start-4 through start-1 are replaced by the start code on the luma and chroma buses. The words are 3FF, 000, 000, status word, and the status word has H bit = 0.
- R3: The samples at pixel numbers stop through stop+3 are replaced by the end code with the same word order, and the status word has H bit = 1.
- R4: The 10-bit status word is laid out as follows: bit 9 is 1, bit 8 is F, bit 7 is V, bit 6 is H, bits 5..2 are V^H, F^H, F^V and F^V^H, and bits 1..0 are 0.
- R5: The line number is 0 for the sample where `vs_in` rises, and it advances by one at each `hs_in` rising edge. V is 1 when line < `cfg_vfirst` or line >= `cfg_vlast`.
- R6: With `cfg_interlaced` = 1, F is 1 exactly when the signed offsets give `cfg_f1_ofs` <= line < `cfg_f0_ofs`. A negative offset therefore takes effect from the vertical sync edge. `fid_out` carries F for each sample.
- R7: With `cfg_interlaced` = 0, F in every status word and `fid_out` are always 0.
- R8: The effective stop position changes only on a write with `wr_sel` = 1. That write loads {`wr_data`[4:0], last byte written with `wr_sel` = 0}. A write with `wr_sel` = 0 on its own leaves the active window unchanged.
- R9: With `cfg_mode422` = 0, active samples pass unchanged: `in_g` to `y_out`, `in_b` to `b_out`, `in_r` to `r_out`. Codes appear on all three buses.
- R10: With `cfg_mode422` = 1, `y_out` carries `in_g`. `b_out` alternates chroma starting at the start pixel: Cb (`in_b`) first when `cfg_cr_first` = 0, Cr (`in_r`) first when it is 1. `r_out` is 0 throughout.
- R11: Non-active slots outside the code words carry 040 on `y_out` and 200 on `b_out`. `r_out` carries 200, or 0 in 4:2:2 mode.
- R12: Reset has the following effect. `av_out` and `fid_out` go to 0 and the buses take the blanking levels. The pixel counter parks at its maximum, so no window opens before the first horizontal sync. The stop position takes its parameter default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| hs_in | input | 1 | Horizontal sync, leading edge rising |
| vs_in | input | 1 | Vertical sync, leading edge rising |
| in_g | input | 10 | Luma / green sample |
| in_b | input | 10 | Cb / blue sample |
| in_r | input | 10 | Cr / red sample |
| cfg_start | input | 13 | First active pixel number |
| cfg_vfirst | input | 12 | First line with V = 0 |
| cfg_vlast | input | 12 | First line with V = 1 again |
| cfg_f1_ofs | input | 8 | Signed line where F becomes 1 |
| cfg_f0_ofs | input | 8 | Signed line where F returns to 0 |
| cfg_interlaced | input | 1 | 1 = interlaced, 0 = progressive |
| cfg_mode422 | input | 1 | 1 = 4:2:2 packing |
| cfg_cr_first | input | 1 | 1 = Cr leads the chroma pair |
| wr_en | input | 1 | Stop register byte write strobe |
| wr_sel | input | 1 | 0 = low byte (staged), 1 = upper bits (commit) |
| wr_data | input | 8 | Write byte |
| y_out | output | 10 | Luma / green bus |
| b_out | output | 10 | Blue bus, or interleaved chroma |
| r_out | output | 10 | Red bus |
| av_out | output | 1 | Active-video flag |
| fid_out | output | 1 | Field ID |

## Verification
Every result of this block is due exactly one rising edge after the sample that causes it. This covers the window flag, the code words, the status bits, the chroma choice and the field ID. The line and pixel decisions for a sample use the sync edges seen in that same sample. The bench drives each sample on a falling edge, lets one rising edge pass, and compares on the next falling edge against a model of pixel number, line number and configuration. Register writes change nothing until a following line, and that line is then checked sample by sample.

// File: rtl/embsync_pkg.sv
package embsync_pkg;

  typedef enum logic [1:0] {
    RGN_BLANK = 2'd0,
    RGN_SAV   = 2'd1,
    RGN_EAV   = 2'd2,
    RGN_ACT   = 2'd3
  } region_e;

  // status byte: 1, F, V, H, then four protection bits
  function automatic logic [7:0] status_bits(input logic f, input logic v, input logic h);
    status_bits = {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

endpackage

// File: rtl/esi_hcount.sv
module esi_hcount
  import embsync_pkg::*;
#(
  parameter int unsigned PIX_W = 13,
  parameter logic [PIX_W-1:0] RST_STOP = 13'd1580
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hs_in,
  input  logic [PIX_W-1:0] cfg_start,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [7:0]       wr_data,
  output logic             hs_lead,
  output region_e          region,
  output logic [1:0]       code_idx,
  output logic             chroma_ph
);

  localparam int unsigned EW   = PIX_W + 1;
  localparam int unsigned HI_W = PIX_W - 8;

  logic             hs_d;
  logic [PIX_W-1:0] pcnt_q;
  logic [PIX_W-1:0] pix;
  logic [PIX_W-1:0] stop_q;
  logic [7:0]       lo_q;
  logic             unused_hi;

  assign unused_hi = ^wr_data[7:HI_W];
  assign hs_lead   = hs_in & ~hs_d;
  assign pix       = hs_lead ? '0 : pcnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_d   <= 1'b0;
      pcnt_q <= '1;
      stop_q <= RST_STOP;
      lo_q   <= '0;
    end else begin
      hs_d <= hs_in;
      if (pix != '1) pcnt_q <= pix + 1'b1;
      else           pcnt_q <= pix;
      if (wr_en) begin
        if (wr_sel) stop_q <= {wr_data[HI_W-1:0], lo_q};
        else        lo_q   <= wr_data;
      end
    end
  end

  logic [EW-1:0] p_x, s_x, e_x;
  logic [EW-1:0] sav_off, eav_off, act_off;
  logic          in_act, in_sav, in_eav;

  assign p_x     = {1'b0, pix};
  assign s_x     = {1'b0, cfg_start};
  assign e_x     = {1'b0, stop_q};
  assign sav_off = p_x + EW'(4) - s_x;
  assign eav_off = p_x - e_x;
  assign act_off = p_x - s_x;

  assign in_act = (p_x >= s_x) && (p_x < e_x);
  assign in_sav = (p_x + EW'(4) >= s_x) && (p_x < s_x);
  assign in_eav = (p_x >= e_x) && (p_x < e_x + EW'(4));

  always_comb begin
    region   = RGN_BLANK;
    code_idx = 2'd0;
    if (in_act) begin
      region = RGN_ACT;
    end else if (in_sav) begin
      region   = RGN_SAV;
      code_idx = sav_off[1:0];
    end else if (in_eav) begin
      region   = RGN_EAV;
      code_idx = eav_off[1:0];
    end
  end

  assign chroma_ph = act_off[0];

endmodule

// File: rtl/esi_vtiming.sv
module esi_vtiming #(
  parameter int unsigned LINE_W = 12,
  parameter int unsigned OFS_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hs_lead,
  input  logic              vs_in,
  input  logic              cfg_interlaced,
  input  logic [LINE_W-1:0] cfg_vfirst,
  input  logic [LINE_W-1:0] cfg_vlast,
  input  logic [OFS_W-1:0]  cfg_f1_ofs,
  input  logic [OFS_W-1:0]  cfg_f0_ofs,
  output logic              v_bit,
  output logic              f_bit
);

  localparam int unsigned SW = LINE_W + 1;

  logic              vs_d;
  logic              vs_lead;
  logic [LINE_W-1:0] lcnt_q;
  logic [LINE_W-1:0] line;

  assign vs_lead = vs_in & ~vs_d;

  always_comb begin
    if (vs_lead)                       line = '0;
    else if (hs_lead && lcnt_q != '1)  line = lcnt_q + 1'b1;
    else                               line = lcnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vs_d   <= 1'b0;
      lcnt_q <= '0;
    end else begin
      vs_d   <= vs_in;
      lcnt_q <= line;
    end
  end

  logic signed [SW-1:0] line_s, f1_s, f0_s;

  assign line_s = $signed({1'b0, line});
  assign f1_s   = $signed({{(SW-OFS_W){cfg_f1_ofs[OFS_W-1]}}, cfg_f1_ofs});
  assign f0_s   = $signed({{(SW-OFS_W){cfg_f0_ofs[OFS_W-1]}}, cfg_f0_ofs});

  assign v_bit = (line < cfg_vfirst) || (line >= cfg_vlast);
  assign f_bit = cfg_interlaced && (line_s >= f1_s) && (line_s < f0_s);

endmodule

// File: rtl/esi_format.sv
module esi_format
  import embsync_pkg::*;
#(
  parameter int unsigned DW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  region_e       region,
  input  logic [1:0]    code_idx,
  input  logic          chroma_ph,
  input  logic          f_bit,
  input  logic          v_bit,
  input  logic          cfg_mode422,
  input  logic          cfg_cr_first,
  input  logic [DW-1:0] in_g,
  input  logic [DW-1:0] in_b,
  input  logic [DW-1:0] in_r,
  output logic [DW-1:0] y_out,
  output logic [DW-1:0] b_out,
  output logic [DW-1:0] r_out,
  output logic          av_out,
  output logic          fid_out
);

  localparam logic [DW-1:0] BLK_Y = DW'(64)  << (DW - 10);
  localparam logic [DW-1:0] BLK_C = DW'(512) << (DW - 10);

  logic [DW-1:0] xy_w, code_w;
  logic [DW-1:0] y_n, b_n, r_n;
  logic          sel_r;

  assign xy_w  = DW'(status_bits(f_bit, v_bit, region == RGN_EAV)) << (DW - 8);
  assign sel_r = chroma_ph ^ cfg_cr_first;

  always_comb begin
    case (code_idx)
      2'd0:    code_w = '1;
      2'd3:    code_w = xy_w;
      default: code_w = '0;
    endcase
  end

  always_comb begin
    case (region)
      RGN_ACT: begin
        y_n = in_g;
        if (cfg_mode422) begin
          b_n = sel_r ? in_r : in_b;
          r_n = '0;
        end else begin
          b_n = in_b;
          r_n = in_r;
        end
      end
      RGN_SAV, RGN_EAV: begin
        y_n = code_w;
        b_n = code_w;
        r_n = cfg_mode422 ? '0 : code_w;
      end
      default: begin
        y_n = BLK_Y;
        b_n = BLK_C;
        r_n = cfg_mode422 ? '0 : BLK_C;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      y_out   <= BLK_Y;
      b_out   <= BLK_C;
      r_out   <= BLK_C;
      av_out  <= 1'b0;
      fid_out <= 1'b0;
    end else begin
      y_out   <= y_n;
      b_out   <= b_n;
      r_out   <= r_n;
      av_out  <= (region == RGN_ACT);
      fid_out <= f_bit;
    end
  end

endmodule

// File: rtl/embsync_inserter.sv
module embsync_inserter
  import embsync_pkg::*;
#(
  parameter int unsigned DW     = 10,
  parameter int unsigned PIX_W  = 13,
  parameter int unsigned LINE_W = 12,
  parameter int unsigned OFS_W  = 8,
  parameter logic [PIX_W-1:0] RST_STOP = 13'd1580
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hs_in,
  input  logic              vs_in,
  input  logic [DW-1:0]     in_g,
  input  logic [DW-1:0]     in_b,
  input  logic [DW-1:0]     in_r,
  input  logic [PIX_W-1:0]  cfg_start,
  input  logic [LINE_W-1:0] cfg_vfirst,
  input  logic [LINE_W-1:0] cfg_vlast,
  input  logic [OFS_W-1:0]  cfg_f1_ofs,
  input  logic [OFS_W-1:0]  cfg_f0_ofs,
  input  logic              cfg_interlaced,
  input  logic              cfg_mode422,
  input  logic              cfg_cr_first,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [7:0]        wr_data,
  output logic [DW-1:0]     y_out,
  output logic [DW-1:0]     b_out,
  output logic [DW-1:0]     r_out,
  output logic              av_out,
  output logic              fid_out
);

  logic       hs_lead;
  region_e    region;
  logic [1:0] code_idx;
  logic       chroma_ph;
  logic       v_bit, f_bit;

  esi_hcount #(.PIX_W(PIX_W), .RST_STOP(RST_STOP)) i_hcount (
    .clk(clk), .rst(rst), .hs_in(hs_in), .cfg_start(cfg_start),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .hs_lead(hs_lead), .region(region), .code_idx(code_idx), .chroma_ph(chroma_ph)
  );

  esi_vtiming #(.LINE_W(LINE_W), .OFS_W(OFS_W)) i_vtiming (
    .clk(clk), .rst(rst), .hs_lead(hs_lead), .vs_in(vs_in),
    .cfg_interlaced(cfg_interlaced), .cfg_vfirst(cfg_vfirst), .cfg_vlast(cfg_vlast),
    .cfg_f1_ofs(cfg_f1_ofs), .cfg_f0_ofs(cfg_f0_ofs),
    .v_bit(v_bit), .f_bit(f_bit)
  );

  esi_format #(.DW(DW)) i_format (
    .clk(clk), .rst(rst), .region(region), .code_idx(code_idx), .chroma_ph(chroma_ph),
    .f_bit(f_bit), .v_bit(v_bit), .cfg_mode422(cfg_mode422), .cfg_cr_first(cfg_cr_first),
    .in_g(in_g), .in_b(in_b), .in_r(in_r),
    .y_out(y_out), .b_out(b_out), .r_out(r_out), .av_out(av_out), .fid_out(fid_out)
  );

endmodule

// File: rtl/embsync_inserter_chk.sv
module embsync_inserter_chk #(
  parameter int unsigned DW    = 10,
  parameter int unsigned PIX_W = 13
) (
  input logic             clk,
  input logic             rst,
  input logic [PIX_W-1:0] cfg_start,
  input logic             cfg_interlaced,
  input logic             cfg_mode422,
  input logic [DW-1:0]    y_out,
  input logic [DW-1:0]    r_out,
  input logic             av_out,
  input logic             fid_out
);

  // R2 R4: the slot before the window opens holds a status word with H = 0
  a_r2_sav_before_window: assert property (@(posedge clk) disable iff (rst)
    ($rose(av_out) && cfg_start >= PIX_W'(4)) |-> ($past(y_out[DW-1]) && !$past(y_out[DW-4])));

  // R3: the window closes on the first end-code word
  a_r3_eav_leads_all_ones: assert property (@(posedge clk) disable iff (rst)
    $fell(av_out) |-> (y_out == '1));

  // R7: progressive operation never shows field 1
  a_r7_progressive_fid_low: assert property (@(posedge clk) disable iff (rst)
    $past(!cfg_interlaced) |-> !fid_out);

  // R10: red bus idle in 4:2:2 packing
  a_r10_red_bus_zero: assert property (@(posedge clk) disable iff (rst)
    $past(cfg_mode422) |-> (r_out == '0));

endmodule

bind embsync_inserter embsync_inserter_chk #(.DW(DW), .PIX_W(PIX_W)) i_chk (
  .clk(clk), .rst(rst), .cfg_start(cfg_start), .cfg_interlaced(cfg_interlaced),
  .cfg_mode422(cfg_mode422), .y_out(y_out), .r_out(r_out), .av_out(av_out), .fid_out(fid_out)
);

// File: tb/test_embsync_inserter.sv
`timescale 1ns/1ps
module test_embsync_inserter;

  localparam int LINE_PIX = 32;
  // stimulus per line: {vs at line start, mode422, cr_first, interlaced}
  localparam logic [3:0] TBL [0:7] = '{
    4'b1001, 4'b0001, 4'b0101, 4'b0111,
    4'b0000, 4'b0100, 4'b1000, 4'b0111
  };

  logic clk = 1'b0;
  logic rst;
  logic hs_in, vs_in;
  logic [9:0] in_g, in_b, in_r;
  logic [12:0] cfg_start;
  logic [11:0] cfg_vfirst, cfg_vlast;
  logic [7:0] cfg_f1_ofs, cfg_f0_ofs;
  logic cfg_interlaced, cfg_mode422, cfg_cr_first;
  logic wr_en, wr_sel;
  logic [7:0] wr_data;
  logic [9:0] y_out, b_out, r_out;
  logic av_out, fid_out;

  int checks = 0;
  int failures = 0;
  int bl = 0;
  int m_stop = 20;
  int m_f1 = 1;
  int m_f0 = 3;
  int cycles = 0;

  int e_av, e_f, e_y, e_b, e_r, rg;

  always #2 clk = ~clk;

  embsync_inserter i_embsync_inserter (.*);

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      failures = failures + 1;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic calc(input int p);
    int s, v, f, h, k, w;
    s = 8;
    if (p >= s && p < m_stop)            rg = 3;
    else if (p + 4 >= s && p < s)        rg = 1;
    else if (p >= m_stop && p < m_stop + 4) rg = 2;
    else                                 rg = 0;
    v = (bl < 2 || bl >= 5) ? 1 : 0;                       // R5
    f = (cfg_interlaced && bl >= m_f1 && bl < m_f0) ? 1 : 0; // R6 R7
    h = (rg == 2) ? 1 : 0;
    e_av = (rg == 3) ? 1 : 0;
    e_f = f;
    k = (rg == 1) ? (p + 4 - s) : (p - m_stop);
    if (k == 0) w = 'h3FF;
    else if (k == 3) w = 'h200 | (f << 8) | (v << 7) | (h << 6) | ((v ^ h) << 5)
                        | ((f ^ h) << 4) | ((f ^ v) << 3) | ((f ^ v ^ h) << 2);
    else w = 0;
    case (rg)
      3: begin
        e_y = 100 + p;
        if (cfg_mode422) begin
          e_b = (((p - s) & 1) ^ cfg_cr_first) ? 500 + p : 300 + p;
          e_r = 0;
        end else begin
          e_b = 300 + p;
          e_r = 500 + p;
        end
      end
      1, 2: begin
        e_y = w; e_b = w; e_r = cfg_mode422 ? 0 : w;
      end
      default: begin
        e_y = 'h040; e_b = 'h200; e_r = cfg_mode422 ? 0 : 'h200;
      end
    endcase
  endtask

  task automatic run_line(input bit vsf);
    if (vsf) bl = 0; else bl = bl + 1;
    for (int p = 0; p < LINE_PIX; p++) begin
      hs_in = (p < 2);
      vs_in = vsf && (p < 2);
      in_g = 10'(100 + p);
      in_b = 10'(300 + p);
      in_r = 10'(500 + p);
      @(posedge clk);
      @(negedge clk);
      calc(p);
      chk(av_out == e_av[0], "R1 active flag", av_out, e_av);
      chk(fid_out == e_f[0], cfg_interlaced ? "R6 field id" : "R7 field id", fid_out, e_f);
      case (rg)
        1: chk(y_out == e_y && b_out == e_b && r_out == e_r, "R2 R4 start code",
               {y_out, b_out, r_out}, {e_y[9:0], e_b[9:0], e_r[9:0]});
        2: chk(y_out == e_y && b_out == e_b && r_out == e_r, "R3 R4 end code",
               {y_out, b_out, r_out}, {e_y[9:0], e_b[9:0], e_r[9:0]});
        3: chk(y_out == e_y && b_out == e_b && r_out == e_r,
               cfg_mode422 ? "R10 packed data" : "R9 full-rate data",
               {y_out, b_out, r_out}, {e_y[9:0], e_b[9:0], e_r[9:0]});
        default: chk(y_out == e_y && b_out == e_b && r_out == e_r, "R11 blanking",
               {y_out, b_out, r_out}, {e_y[9:0], e_b[9:0], e_r[9:0]});
      endcase
    end
    hs_in = 1'b0;
    vs_in = 1'b0;
  endtask

  task automatic write_reg(input bit sel, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    rst = 1'b1;
    hs_in = 0; vs_in = 0; in_g = 0; in_b = 0; in_r = 0;
    cfg_start = 13'd8; cfg_vfirst = 12'd2; cfg_vlast = 12'd5;
    cfg_f1_ofs = 8'd1; cfg_f0_ofs = 8'd3;
    cfg_interlaced = 0; cfg_mode422 = 0; cfg_cr_first = 0;
    wr_en = 0; wr_sel = 0; wr_data = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R12: reset state
    chk(av_out == 0 && fid_out == 0, "R12 reset flags", {av_out, fid_out}, 0);
    chk(y_out == 10'h040 && b_out == 10'h200 && r_out == 10'h200, "R12 reset buses",
        {y_out, b_out, r_out}, {10'h040, 10'h200, 10'h200});
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    // R12: no window before the first horizontal sync
    chk(av_out == 0 && y_out == 10'h040, "R12 idle after reset", {av_out, y_out}, 10'h040);

    // stop position 20 (R8)
    write_reg(1'b0, 8'd20);
    write_reg(1'b1, 8'd0);

    for (int i = 0; i < 8; i++) begin
      cfg_mode422    = TBL[i][2];
      cfg_cr_first   = TBL[i][1];
      cfg_interlaced = TBL[i][0];
      run_line(TBL[i][3]);
    end

    // R8: low byte alone leaves the window as it was
    cfg_mode422 = 0; cfg_cr_first = 0; cfg_interlaced = 0;
    write_reg(1'b0, 8'd16);
    run_line(1'b0);
    // R8: upper write commits stop = 16
    write_reg(1'b1, 8'd0);
    m_stop = 16;
    run_line(1'b0);

    // R6: negative first offset, F from the sync edge up to line 1
    cfg_interlaced = 1;
    cfg_f1_ofs = 8'hFE; m_f1 = -2;
    cfg_f0_ofs = 8'd1;  m_f0 = 1;
    run_line(1'b1);
    run_line(1'b0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule